// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers interrupt events from two groups of sources and presents them to software through a small register port. The first group is bus-side events, spread over a low and a high status word. The second group is DMA-side events, held in one status word. Every status word has its own enable mask. An event is recorded only on bits whose enable is set. A summary register shows one pending flag per group, plus an on-the-fly flag. Software can poll the summary register at any time. One active-low request line, `irq_n`, is driven from the same state.

Group status words are read-to-clear. The on-the-fly flag is different: it is cleared only by writing one to it. While it is set, it takes priority. The group flags in the summary read as zero, and reads of the group words return zero and clear nothing. The latched group bits are kept intact until the flag is cleared.

One bus-side bit is a fatal receive condition. If it arrives while a receive is in progress, it is not latched straight away. The block first raises a flush request toward the data FIFO. The bit is recorded only when the FIFO reports that it is empty. The FIFO storage, the DMA engine and the bus protocol lie outside this block.

The interfaces are plain control pins: register strobes, single-cycle event strobes, and a level request/acknowledge pair for the flush. No data stream passes through the block, so there is no valid/ready back-pressure. Every register access completes in the cycle its strobe is high.

Top module: `irq_hier_ctrl`

## Requirements
- R1: An event strobe on an enabled bit is latched into its status word on the clock edge where the strobe is high, and is readable from the next cycle. A strobe on a disabled bit is not recorded. Register addresses are: 0 summary, 1 bus low word, 2 bus high word, 3 DMA word.
- R2: Summary bit 0 reads 1 when any enabled bit of either bus word is latched. Summary bit 1 reads 1 when any enabled DMA bit is latched. Both can read 1 together.
- R3: Reading the bus low or bus high word returns its latched bits and clears them on that clock edge. A bus event in the same cycle as the read stays latched.
- R4: Reading the DMA word returns its latched bits and clears them on that clock edge. A DMA event in the same cycle as the read stays latched.
- R5: Summary bit 2 is the on-the-fly flag. `otf_evt` sets it. It clears only on a write to address 0 with data bit 2 equal to 1. A write with bit 2 equal to 0 leaves it set.
- R6: While the on-the-fly flag is set:
  - summary bits 0 and 1 read 0;
  - reads of addresses 1 to 3 return 0 and clear nothing;
  - the latched bits appear again once the flag is cleared.
- R7: Bit FATAL_BIT (default 2) of the bus low word is the fatal receive condition. If its enabled event arrives while `rx_active` is 1, it is not latched. `flush_req` is driven high from the next cycle. The bit is latched, and `flush_req` drops, on the first edge where `fifo_empty` is 1.
- R8: `irq_n` is low exactly while the on-the-fly flag or any enabled latched status bit is set. It goes high directly after the edge that clears the last such bit.
- R9: After reset, all status words, enable masks and the on-the-fly flag are 0, `flush_req` is 0 and `irq_n` is 1.
- R10: Enable masks are written and read back at addresses 4 (bus low), 5 (bus high) and 6 (DMA).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe; read data is combinational in the same cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| ev_bus_lo | input | BUS0_W | Bus-side event strobes, low word |
| ev_bus_hi | input | BUS1_W | Bus-side event strobes, high word |
| ev_dma | input | DMA_W | DMA-side event strobes |
| otf_evt | input | 1 | On-the-fly interrupt event strobe |
| rx_active | input | 1 | High while a receive transfer is in progress |
| fifo_empty | input | 1 | Data FIFO has drained to memory |
| flush_req | output | 1 | Request to flush the data FIFO |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data is combinational. The bench samples it 1 ns after it drives a read strobe on a falling edge, so the sample comes before the edge that clears the word. An event strobe driven on a falling edge is latched at the next rising edge. The resulting status word, summary flags and `irq_n` are checked at the falling edge that follows, one cycle after the stimulus. `flush_req` is checked one cycle after the fatal strobe, held across several stalled cycles, and checked low again in the cycle after `fifo_empty` is seen. The release of the on-the-fly flag is checked at the cycle after the clearing write.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SUMMARY = 3'd0,
    A_BUS_LO  = 3'd1,
    A_BUS_HI  = 3'd2,
    A_DMA     = 3'd3,
    A_EN_LO   = 3'd4,
    A_EN_HI   = 3'd5,
    A_EN_DMA  = 3'd6
  } reg_addr_e;

  // summary register bit positions
  localparam int SUM_BUS_BIT = 0;
  localparam int SUM_DMA_BIT = 1;
  localparam int SUM_OTF_BIT = 2;
endpackage

// File: rtl/irq_stat_word.sv
// One latched status word: records enabled events, clears on read.
module irq_stat_word #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  input  logic         rd_clr,
  output logic [W-1:0] stat,
  output logic         pend
);
  logic [W-1:0] stat_n;

  // a new event wins over a clearing read in the same cycle
  always_comb stat_n = (stat & ~{W{rd_clr}}) | (ev & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_n;
  end

  assign pend = |(stat & en);
endmodule

// File: rtl/irq_flush_gate.sv
// Holds a fatal receive-side event until the data FIFO reports empty.
module irq_flush_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fatal_ev,
  input  logic fifo_empty,
  output logic flush_req,
  output logic release_ev
);
  logic hold_q;

  assign release_ev = hold_q & fifo_empty;
  assign flush_req  = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= (hold_q & ~fifo_empty) | fatal_ev;
  end
endmodule

// File: rtl/irq_regfile.sv
// Enable masks, address decode, read mux and clear strobes.
module irq_regfile
  import irq_hier_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS0_W = 8,
  parameter int BUS1_W = 8,
  parameter int DMA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [BUS0_W-1:0] stat_lo,
  input  logic [BUS1_W-1:0] stat_hi,
  input  logic [DMA_W-1:0]  stat_dma,
  input  logic [DATA_W-1:0] summary,
  input  logic              otf_q,
  output logic [BUS0_W-1:0] en_lo,
  output logic [BUS1_W-1:0] en_hi,
  output logic [DMA_W-1:0]  en_dma,
  output logic              clr_lo,
  output logic              clr_hi,
  output logic              clr_dma,
  output logic              otf_clr
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(reg_addr);

  // group words are frozen while the on-the-fly flag is set
  assign clr_lo  = rd_en && (sel == A_BUS_LO) && !otf_q;
  assign clr_hi  = rd_en && (sel == A_BUS_HI) && !otf_q;
  assign clr_dma = rd_en && (sel == A_DMA)    && !otf_q;
  assign otf_clr = wr_en && (sel == A_SUMMARY) && wr_data[SUM_OTF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo  <= '0;
      en_hi  <= '0;
      en_dma <= '0;
    end else if (wr_en) begin
      case (sel)
        A_EN_LO:  en_lo  <= wr_data[BUS0_W-1:0];
        A_EN_HI:  en_hi  <= wr_data[BUS1_W-1:0];
        A_EN_DMA: en_dma <= wr_data[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      A_SUMMARY: rd_data = summary;
      A_BUS_LO:  rd_data = otf_q ? '0 : DATA_W'(stat_lo);
      A_BUS_HI:  rd_data = otf_q ? '0 : DATA_W'(stat_hi);
      A_DMA:     rd_data = otf_q ? '0 : DATA_W'(stat_dma);
      A_EN_LO:   rd_data = DATA_W'(en_lo);
      A_EN_HI:   rd_data = DATA_W'(en_hi);
      A_EN_DMA:  rd_data = DATA_W'(en_dma);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_summary.sv
// On-the-fly flag, gated group flags and the request line.
module irq_summary
  import irq_hier_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              otf_evt,
  input  logic              otf_clr,
  input  logic              pend_bus,
  input  logic              pend_dma,
  output logic              otf_q,
  output logic [DATA_W-1:0] summary,
  output logic              irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) otf_q <= 1'b0;
    else        otf_q <= otf_evt | (otf_q & ~otf_clr);
  end

  always_comb begin
    summary = '0;
    summary[SUM_BUS_BIT] = pend_bus & ~otf_q;
    summary[SUM_DMA_BIT] = pend_dma & ~otf_q;
    summary[SUM_OTF_BIT] = otf_q;
  end

  assign irq_n = ~(otf_q | pend_bus | pend_dma);
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_hier_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUS0_W    = 8,
  parameter int BUS1_W    = 8,
  parameter int DMA_W     = 8,
  parameter int FATAL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [BUS0_W-1:0] ev_bus_lo,
  input  logic [BUS1_W-1:0] ev_bus_hi,
  input  logic [DMA_W-1:0]  ev_dma,
  input  logic              otf_evt,
  input  logic              rx_active,
  input  logic              fifo_empty,
  output logic              flush_req,
  output logic              irq_n
);
  localparam logic [BUS0_W-1:0] FATAL_MASK = BUS0_W'(1) << FATAL_BIT;

  logic [BUS0_W-1:0] stat_lo, en_lo, ev_lo_eff;
  logic [BUS1_W-1:0] stat_hi, en_hi;
  logic [DMA_W-1:0]  stat_dma, en_dma;
  logic [DATA_W-1:0] summary;
  logic clr_lo, clr_hi, clr_dma, otf_clr, otf_q;
  logic pend_lo, pend_hi, pend_dma;
  logic fatal_ev, fatal_rel;

  // a fatal event during receive is diverted through the flush gate
  assign fatal_ev  = rx_active & ev_bus_lo[FATAL_BIT] & en_lo[FATAL_BIT];
  assign ev_lo_eff = (rx_active ? (ev_bus_lo & ~FATAL_MASK) : ev_bus_lo)
                   | (fatal_rel ? FATAL_MASK : '0);

  irq_flush_gate u_flush (
    .clk(clk), .rst_n(rst_n), .fatal_ev(fatal_ev), .fifo_empty(fifo_empty),
    .flush_req(flush_req), .release_ev(fatal_rel)
  );

  irq_stat_word #(.W(BUS0_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .ev(ev_lo_eff), .en(en_lo), .rd_clr(clr_lo),
    .stat(stat_lo), .pend(pend_lo)
  );
  irq_stat_word #(.W(BUS1_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .ev(ev_bus_hi), .en(en_hi), .rd_clr(clr_hi),
    .stat(stat_hi), .pend(pend_hi)
  );
  irq_stat_word #(.W(DMA_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .ev(ev_dma), .en(en_dma), .rd_clr(clr_dma),
    .stat(stat_dma), .pend(pend_dma)
  );

  irq_regfile #(.DATA_W(DATA_W), .BUS0_W(BUS0_W), .BUS1_W(BUS1_W), .DMA_W(DMA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .stat_lo(stat_lo), .stat_hi(stat_hi),
    .stat_dma(stat_dma), .summary(summary), .otf_q(otf_q), .en_lo(en_lo),
    .en_hi(en_hi), .en_dma(en_dma), .clr_lo(clr_lo), .clr_hi(clr_hi),
    .clr_dma(clr_dma), .otf_clr(otf_clr)
  );

  irq_summary #(.DATA_W(DATA_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .otf_evt(otf_evt), .otf_clr(otf_clr),
    .pend_bus(pend_lo | pend_hi), .pend_dma(pend_dma), .otf_q(otf_q),
    .summary(summary), .irq_n(irq_n)
  );
endmodule

// File: rtl/irq_hier_checker.sv
module irq_hier_checker #(
  parameter int BUS0_W = 8,
  parameter int BUS1_W = 8,
  parameter int DMA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic              flush_req,
  input logic              fifo_empty,
  input logic              rx_active,
  input logic              otf_q,
  input logic              otf_clr,
  input logic              otf_evt,
  input logic              rd_en,
  input logic [2:0]        reg_addr,
  input logic [BUS1_W-1:0] ev_bus_hi,
  input logic [BUS0_W-1:0] stat_lo,
  input logic [BUS1_W-1:0] stat_hi,
  input logic [DMA_W-1:0]  stat_dma
);
  a_r5_otf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    otf_q && !otf_clr |=> otf_q);

  a_r5_otf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    otf_q && otf_clr && !otf_evt |=> !otf_q);

  a_r6_frozen_dma: assert property (@(posedge clk) disable iff (!rst_n)
    otf_q |=> (($past(stat_dma) & ~stat_dma) == '0));

  a_r6_frozen_lo: assert property (@(posedge clk) disable iff (!rst_n)
    otf_q |=> (($past(stat_lo) & ~stat_lo) == '0));

  a_r3_hi_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_addr == 3'd2 && !otf_q && ev_bus_hi == '0 |=> stat_hi == '0);

  a_r7_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !fifo_empty |=> flush_req);

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(rx_active));

  a_r8_otf_requests: assert property (@(posedge clk) disable iff (!rst_n)
    otf_q |-> !irq_n);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !otf_q && stat_lo == '0 && stat_hi == '0 && stat_dma == '0 |-> irq_n);
endmodule

bind irq_hier_ctrl irq_hier_checker #(.BUS0_W(BUS0_W), .BUS1_W(BUS1_W), .DMA_W(DMA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .flush_req(flush_req),
  .fifo_empty(fifo_empty), .rx_active(rx_active), .otf_q(otf_q),
  .otf_clr(otf_clr), .otf_evt(otf_evt), .rd_en(rd_en), .reg_addr(reg_addr),
  .ev_bus_hi(ev_bus_hi), .stat_lo(stat_lo), .stat_hi(stat_hi), .stat_dma(stat_dma)
);

// File: tb/irq_hier_ctrl_bench.sv
`timescale 1ns/1ps
module irq_hier_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic rd_en = 0, wr_en = 0, otf_evt = 0, rx_active = 0, fifo_empty = 0;
  logic [7:0] wr_data = '0, ev_bus_lo = '0, ev_bus_hi = '0, ev_dma = '0;
  logic [7:0] rd_data;
  logic flush_req, irq_n;
  int n_tests = 0, n_fail = 0;
  logic [7:0] en_val [3];
  logic [7:0] r;

  always #4 clk = ~clk;

  irq_hier_ctrl u_irq_hier_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ev_bus_lo(ev_bus_lo), .ev_bus_hi(ev_bus_hi),
    .ev_dma(ev_dma), .otf_evt(otf_evt), .rx_active(rx_active), .fifo_empty(fifo_empty),
    .flush_req(flush_req), .irq_n(irq_n)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; rd_en = 1'b1; #1; d = rd_data;
    tick(); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    tick(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input int w, input logic [7:0] v);
    case (w)
      0: ev_bus_lo = v;
      1: ev_bus_hi = v;
      default: ev_dma = v;
    endcase
    tick();
    ev_bus_lo = '0; ev_bus_hi = '0; ev_dma = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    en_val[0] = 8'hA5; en_val[1] = 8'h3C; en_val[2] = 8'hFF;
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9 irq_n at reset", {7'd0, irq_n}, 8'h01);
    chk("R9 flush_req at reset", {7'd0, flush_req}, 8'h00);
    rst_n = 1'b1;
    tick();
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), r); chk($sformatf("R9 reg %0d after reset", a), r, 8'h00);
    end

    // R10: enable masks read back
    for (int w = 0; w < 3; w++) wr(3'(w + 4), en_val[w]);
    for (int w = 0; w < 3; w++) begin
      rd(3'(w + 4), r); chk($sformatf("R10 enable %0d", w), r, en_val[w]);
    end

    // R1 R2 R3 R4 R8: sweep every bit of every word, enabled and disabled
    for (int w = 0; w < 3; w++) begin
      for (int b = 0; b < 8; b++) begin
        logic [7:0] exp_w;
        logic [7:0] exp_s;
        exp_w = (8'h01 << b) & en_val[w];
        exp_s = (exp_w == 0) ? 8'h00 : ((w == 2) ? 8'h02 : 8'h01);
        pulse(w, 8'h01 << b);
        chk($sformatf("R8 irq_n w%0d b%0d", w, b), {7'd0, irq_n}, (exp_w == 0) ? 8'h01 : 8'h00);
        rd(3'd0, r); chk($sformatf("R2 summary w%0d b%0d", w, b), r, exp_s);
        rd(3'(w + 1), r); chk($sformatf("R1 latch w%0d b%0d", w, b), r, exp_w);
        rd(3'(w + 1), r); chk($sformatf("%s cleared w%0d b%0d", (w == 2) ? "R4" : "R3", w, b), r, 8'h00);
        chk($sformatf("R8 irq_n released w%0d b%0d", w, b), {7'd0, irq_n}, 8'h01);
      end
    end

    // R2: both groups pending together
    ev_bus_hi = 8'h04; ev_dma = 8'h01; tick(); ev_bus_hi = '0; ev_dma = '0;
    rd(3'd0, r); chk("R2 both groups", r, 8'h03);
    rd(3'd2, r); rd(3'd0, r); chk("R2 dma only left", r, 8'h02);
    rd(3'd3, r); chk("R8 irq_n idle", {7'd0, irq_n}, 8'h01);

    // R4: event coincident with clearing read survives
    pulse(2, 8'h02);
    reg_addr = 3'd3; rd_en = 1'b1; ev_dma = 8'h08; #1; r = rd_data;
    tick(); rd_en = 1'b0; ev_dma = '0;
    chk("R4 read value", r, 8'h02);
    rd(3'd3, r); chk("R4 coincident event kept", r, 8'h08);

    // R3: same for bus high word
    pulse(1, 8'h10);
    reg_addr = 3'd2; rd_en = 1'b1; ev_bus_hi = 8'h20; #1; r = rd_data;
    tick(); rd_en = 1'b0; ev_bus_hi = '0;
    chk("R3 read value", r, 8'h10);
    rd(3'd2, r); chk("R3 coincident event kept", r, 8'h20);

    // R5 R6: on-the-fly priority
    ev_dma = 8'h01; otf_evt = 1'b1; tick(); ev_dma = '0; otf_evt = 1'b0;
    rd(3'd0, r); chk("R6 summary masked", r, 8'h04);
    chk("R8 irq_n with otf", {7'd0, irq_n}, 8'h00);
    rd(3'd3, r); chk("R6 group read hidden", r, 8'h00);
    wr(3'd0, 8'h03);
    rd(3'd0, r); chk("R5 write zero keeps flag", r, 8'h04);
    wr(3'd0, 8'h04);
    rd(3'd0, r); chk("R6 released after clear", r, 8'h02);
    rd(3'd3, r); chk("R6 dma bit preserved", r, 8'h01);
    rd(3'd3, r); chk("R4 cleared after release", r, 8'h00);
    chk("R8 irq_n after all cleared", {7'd0, irq_n}, 8'h01);

    // R7: fatal receive waits for flush
    rx_active = 1'b1; fifo_empty = 1'b0;
    pulse(0, 8'h05);
    chk("R7 flush_req raised", {7'd0, flush_req}, 8'h01);
    rd(3'd1, r); chk("R7 only non-fatal bit latched", r, 8'h01);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R7 flush_req held", {7'd0, flush_req}, 8'h01);
    end
    chk("R8 irq_n quiet during flush", {7'd0, irq_n}, 8'h01);
    fifo_empty = 1'b1; tick();
    chk("R7 flush_req dropped", {7'd0, flush_req}, 8'h00);
    chk("R8 irq_n after flush", {7'd0, irq_n}, 8'h00);
    rd(3'd1, r); chk("R7 fatal latched", r, 8'h04);
    // R7: disabled fatal bit raises no flush
    wr(3'd4, 8'hA1); fifo_empty = 1'b0;
    pulse(0, 8'h04);
    chk("R7 disabled fatal no flush", {7'd0, flush_req}, 8'h00);
    rd(3'd1, r); chk("R1 disabled fatal not latched", r, 8'h00);
    rx_active = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule